// File: doc/BRIEF.md
# Motor Drive Safety Interlock Latch

This block sits between the firmware PWM request and the enable pin of a three-phase gate driver. It watches two hardware trip sources (an active-low emergency-stop input from a normally closed switch and an overcurrent comparator), a digitized DC-bus voltage, and a stall flag from the speed-sensing logic. Every detected condition is held in its own fault latch. The gate driver runs only while firmware asks for PWM, no hardware trip input is active and no fault is latched.

The two hardware trips reach the gate-enable and force-off outputs through combinational logic alone, so no clock edge or software step sits on that path. A latch then holds the trip after the input recovers. Bus overvoltage, bus undervoltage and stall are compared against parameterised limits and latched at the clock edge. A priority-encoded fault code byte feeds the status reports.

Latched faults are released only by an explicit clear command byte. A clear releases only the faults whose causing condition has gone at that moment. The PWM request can only take the drive away and can never re-enable a latched fault. All control and status pins are plain levels with no handshake.

Top module: `mdrv_interlock`

## Requirements
- R1: While `estop_n` is low, `gate_en` is low and `force_off` is high in the same cycle, with no clock edge needed.
- R2: While `ocp_trip` is high, `gate_en` is low and `force_off` is high in the same cycle, with no clock edge needed.
- R3: A hardware trip seen at a clock edge is latched. After that edge, `force_off` stays high and `gate_en` stays low even once the trip input has returned to inactive, until the fault is cleared.
- R4: A clock edge with `vbus_code` strictly above `OV_LIMIT` (default 2400) latches an overvoltage fault. A value equal to `OV_LIMIT` does not.
- R5: A clock edge with `vbus_code` strictly below `UV_LIMIT` (default 1440) latches an undervoltage fault. A value equal to `UV_LIMIT` does not.
- R6: A clock edge with `stall_flag` high latches a stall fault.
- R7: `fault_code` reports the lowest code among the latched faults: 0 none, 1 emergency stop, 2 overcurrent, 3 overvoltage, 4 undervoltage, 5 stall. It changes at the same edge that sets or clears the latch.
- R8: A clock edge with `cmd_valid` high and `cmd_byte` equal to `CLR_CODE` (default 8'h03) releases every latched fault whose condition is absent at that edge. Faults whose condition is still present stay latched. Any other byte value has no effect.
- R9: The undervoltage fault can be released only when `vbus_code` is at least `UV_LIMIT + UV_HYST` (default 1448).
- R10: `gate_en` is high only when `pwm_req` is high, `estop_n` is high, `ocp_trip` is low and no fault is latched. Dropping `pwm_req` always drops `gate_en`.
- R11: While `rst_n` is low, every fault latch is cleared and `gate_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| estop_n | input | 1 | Emergency-stop loop, low or open means stop |
| ocp_trip | input | 1 | Overcurrent comparator output, high means trip |
| vbus_code | input | VBUS_W | DC-bus voltage in ADC counts |
| stall_flag | input | 1 | Stall indication from speed sensing |
| pwm_req | input | 1 | Firmware request to drive the bridge |
| cmd_valid | input | 1 | Qualifies `cmd_byte` for one cycle |
| cmd_byte | input | 8 | Host command byte |
| gate_en | output | 1 | Gate driver enable |
| force_off | output | 1 | Force all six bridge switches off (coast) |
| fault_code | output | 8 | Highest-priority latched fault code |

## Verification
Directed sequences step the bus voltage onto each limit and one count past it. This separates strict from non-strict comparisons. They also park the bus inside the undervoltage hysteresis band during a clear, which separates the release threshold from the trip threshold. Further sequences issue clears while a condition is still present, or with a wrong command byte. These separate a conditional release from an unconditional one. Overlapping faults with a partial clear show whether the code follows priority or arrival order, and probes taken before any clock edge show whether the hardware trips are combinational. A long random phase mixes all sources with biased probabilities, and every cycle is compared against a reference model of the latches.

// File: rtl/mdrv_pkg.sv
package mdrv_pkg;
  localparam int NSRC = 5;

  // latch index; index + 1 is the reported code, so order is priority
  localparam int SRC_ESTOP = 0;
  localparam int SRC_OCP   = 1;
  localparam int SRC_OV    = 2;
  localparam int SRC_UV    = 3;
  localparam int SRC_STALL = 4;

  typedef enum logic [2:0] {
    FLT_NONE  = 3'd0,
    FLT_ESTOP = 3'd1,
    FLT_OCP   = 3'd2,
    FLT_OV    = 3'd3,
    FLT_UV    = 3'd4,
    FLT_STALL = 3'd5
  } flt_e;
endpackage

// File: rtl/mdrv_fault_latch.sv
module mdrv_fault_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_req_i,
  input  logic clr_ok_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)                      q_o <= 1'b0;
    else if (set_i)                  q_o <= 1'b1;
    else if (clr_req_i && clr_ok_i)  q_o <= 1'b0;
  end

  // R3: a latched fault persists without a qualified clear
  a_r3_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (q_o && !(clr_req_i && clr_ok_i)) |=> q_o);
  // R8: release only through a qualified clear with the cause gone
  a_r8_release_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(q_o) |-> $past(clr_req_i && clr_ok_i && !set_i));
  // R11: reset leaves the latch empty
  a_r11_reset_clears: assert property (@(posedge clk)
    !rst_n |=> !q_o);
endmodule

// File: rtl/mdrv_bus_monitor.sv
module mdrv_bus_monitor #(
  parameter int VBUS_W   = 12,
  parameter int OV_LIMIT = 2400,
  parameter int UV_LIMIT = 1440,
  parameter int UV_HYST  = 8
) (
  input  logic [VBUS_W-1:0] vbus_i,
  output logic              ov_cond_o,
  output logic              uv_cond_o,
  output logic              ov_clr_ok_o,
  output logic              uv_clr_ok_o
);
  localparam logic [VBUS_W:0] OV_L  = (VBUS_W+1)'(OV_LIMIT);
  localparam logic [VBUS_W:0] UV_L  = (VBUS_W+1)'(UV_LIMIT);
  localparam logic [VBUS_W:0] UV_RL = (VBUS_W+1)'(UV_LIMIT + UV_HYST);

  logic [VBUS_W:0] v;
  assign v = {1'b0, vbus_i};

  assign ov_cond_o   = v > OV_L;
  assign uv_cond_o   = v < UV_L;
  assign ov_clr_ok_o = v <= OV_L;
  assign uv_clr_ok_o = v >= UV_RL;

  // R9: release threshold sits above the trip threshold
  always_comb begin
    if (uv_clr_ok_o) a_r9_hyst_band: assert (!uv_cond_o);
  end
endmodule

// File: rtl/mdrv_fault_encoder.sv
module mdrv_fault_encoder
  import mdrv_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] flags_i,
  output logic [7:0]   code_o
);
  always_comb begin
    code_o = 8'(FLT_NONE);
    for (int i = N - 1; i >= 0; i--) begin
      if (flags_i[i]) code_o = 8'(i + 1);
    end
  end

  // R7: zero code exactly when nothing is latched
  a_r7_code_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (code_o == 8'd0) == (flags_i == '0));
  // R7: the reported source is itself latched
  a_r7_code_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (code_o != 8'd0) |-> flags_i[code_o[2:0] - 3'd1]);
endmodule

// File: rtl/mdrv_interlock.sv
module mdrv_interlock
  import mdrv_pkg::*;
#(
  parameter int          VBUS_W   = 12,
  parameter int          OV_LIMIT = 2400,
  parameter int          UV_LIMIT = 1440,
  parameter int          UV_HYST  = 8,
  parameter logic [7:0]  CLR_CODE = 8'h03
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              estop_n,
  input  logic              ocp_trip,
  input  logic [VBUS_W-1:0] vbus_code,
  input  logic              stall_flag,
  input  logic              pwm_req,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_byte,
  output logic              gate_en,
  output logic              force_off,
  output logic [7:0]        fault_code
);
  logic [NSRC-1:0] cond, clr_ok, lat;
  logic            ov_c, uv_c, ov_ok, uv_ok;
  logic            clr_req, hw_active, hw_kill;

  mdrv_bus_monitor #(
    .VBUS_W(VBUS_W), .OV_LIMIT(OV_LIMIT),
    .UV_LIMIT(UV_LIMIT), .UV_HYST(UV_HYST)
  ) u_bus (
    .vbus_i(vbus_code), .ov_cond_o(ov_c), .uv_cond_o(uv_c),
    .ov_clr_ok_o(ov_ok), .uv_clr_ok_o(uv_ok)
  );

  always_comb begin
    cond[SRC_ESTOP]   = !estop_n;
    cond[SRC_OCP]     = ocp_trip;
    cond[SRC_OV]      = ov_c;
    cond[SRC_UV]      = uv_c;
    cond[SRC_STALL]   = stall_flag;
    clr_ok[SRC_ESTOP] = estop_n;
    clr_ok[SRC_OCP]   = !ocp_trip;
    clr_ok[SRC_OV]    = ov_ok;
    clr_ok[SRC_UV]    = uv_ok;
    clr_ok[SRC_STALL] = !stall_flag;
  end

  assign clr_req = cmd_valid && (cmd_byte == CLR_CODE);

  for (genvar g = 0; g < NSRC; g++) begin : g_lat
    mdrv_fault_latch u_lat (
      .clk(clk), .rst_n(rst_n), .set_i(cond[g]),
      .clr_req_i(clr_req), .clr_ok_i(clr_ok[g]), .q_o(lat[g])
    );
  end

  mdrv_fault_encoder #(.N(NSRC)) u_enc (
    .clk(clk), .rst_n(rst_n), .flags_i(lat), .code_o(fault_code)
  );

  // hardware trip path: no register between the pins and the outputs
  assign hw_active = !estop_n || ocp_trip;
  assign hw_kill   = hw_active || lat[SRC_ESTOP] || lat[SRC_OCP];
  assign force_off = hw_kill;
  assign gate_en   = rst_n && pwm_req && !hw_kill && (lat == '0);

  // R1 / R2: live trips kill the gate at once
  a_r1_estop_kills: assert property (@(posedge clk) disable iff (!rst_n)
    !estop_n |-> (!gate_en && force_off));
  a_r2_ocp_kills: assert property (@(posedge clk) disable iff (!rst_n)
    ocp_trip |-> (!gate_en && force_off));
  // R4: overvoltage reading latches at the edge
  a_r4_ov_latches: assert property (@(posedge clk) disable iff (!rst_n)
    (vbus_code > VBUS_W'(OV_LIMIT)) |=> (fault_code != 8'd0) && !gate_en);
  // R10: request cannot override a latched fault
  a_r10_no_override: assert property (@(posedge clk) disable iff (!rst_n)
    (lat != '0) |-> !gate_en);
  a_r10_req_low: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_req |-> !gate_en);
endmodule

// File: tb/mdrv_interlock_test.sv
module mdrv_interlock_test;
  localparam int         W    = 12;
  localparam int         OVL  = 2400;
  localparam int         UVL  = 1440;
  localparam int         HYS  = 8;
  localparam logic [7:0] CLRC = 8'h03;

  logic clk = 1'b0, rst_n = 1'b0;
  logic estop_n = 1'b1, ocp_trip = 1'b0, stall_flag = 1'b0, pwm_req = 1'b1;
  logic cmd_valid = 1'b0;
  logic [7:0] cmd_byte = 8'h00;
  logic [W-1:0] vbus_code = W'(1920);
  logic gate_en, force_off;
  logic [7:0] fault_code;

  int total = 0, bad = 0;
  bit done = 0;
  logic [4:0] m_lat = '0;

  always #4 clk = ~clk;

  mdrv_interlock #(.VBUS_W(W), .OV_LIMIT(OVL), .UV_LIMIT(UVL),
                   .UV_HYST(HYS), .CLR_CODE(CLRC)) uut (
    .clk(clk), .rst_n(rst_n), .estop_n(estop_n), .ocp_trip(ocp_trip),
    .vbus_code(vbus_code), .stall_flag(stall_flag), .pwm_req(pwm_req),
    .cmd_valid(cmd_valid), .cmd_byte(cmd_byte), .gate_en(gate_en),
    .force_off(force_off), .fault_code(fault_code)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [4:0] next_lat(input logic [4:0] l);
    logic [4:0] c, ok, n;
    bit clr;
    c  = {stall_flag, (int'(vbus_code) < UVL), (int'(vbus_code) > OVL), ocp_trip, !estop_n};
    ok = {!stall_flag, (int'(vbus_code) >= UVL + HYS), (int'(vbus_code) <= OVL), !ocp_trip, estop_n};
    clr = cmd_valid && (cmd_byte == CLRC);
    for (int i = 0; i < 5; i++)
      n[i] = c[i] ? 1'b1 : ((clr && ok[i]) ? 1'b0 : l[i]);
    if (!rst_n) n = '0;
    return n;
  endfunction

  function automatic int exp_code(input logic [4:0] l);
    for (int i = 0; i < 5; i++) if (l[i]) return i + 1;
    return 0;
  endfunction

  function automatic bit exp_gate(input logic [4:0] l);
    return rst_n && pwm_req && estop_n && !ocp_trip && (l == '0);
  endfunction

  function automatic bit exp_force(input logic [4:0] l);
    return !estop_n || ocp_trip || l[0] || l[1];
  endfunction

  task automatic cmp_all();
    chk(gate_en == exp_gate(m_lat), "R10 gate", int'(gate_en), int'(exp_gate(m_lat)));
    chk(force_off == exp_force(m_lat), "R3 force", int'(force_off), int'(exp_force(m_lat)));
    chk(fault_code == 8'(exp_code(m_lat)), "R7 code", int'(fault_code), exp_code(m_lat));
  endtask

  // one clock: model follows the inputs present at the edge, then compare
  task automatic step();
    logic [4:0] n;
    n = next_lat(m_lat);
    @(posedge clk);
    m_lat = n;
    #2;
    cmp_all();
    cmd_valid = 1'b0;
  endtask

  task automatic clear_cmd(input logic [7:0] b);
    cmd_valid = 1'b1;
    cmd_byte = b;
    step();
  endtask

  initial begin
    void'($urandom(32'd1234));
    // R11: reset state
    repeat (2) @(posedge clk);
    #2;
    chk(gate_en == 1'b0, "R11 gate in reset", int'(gate_en), 0);
    rst_n = 1'b1;
    step();
    chk(fault_code == 8'd0, "R11 code after reset", int'(fault_code), 0);
    chk(gate_en == 1'b1, "R10 gate running", int'(gate_en), 1);

    // R1: emergency stop, combinational before any edge
    estop_n = 1'b0;
    #1;
    chk(gate_en == 1'b0, "R1 gate", int'(gate_en), 0);
    chk(force_off == 1'b1, "R1 force", int'(force_off), 1);
    step();
    chk(fault_code == 8'd1, "R7 estop code", int'(fault_code), 1);
    estop_n = 1'b1;
    step();
    chk(force_off == 1'b1 && gate_en == 1'b0, "R3 estop held", int'(force_off), 1);
    clear_cmd(8'h05);
    chk(fault_code == 8'd1, "R8 wrong byte ignored", int'(fault_code), 1);
    estop_n = 1'b0;
    clear_cmd(CLRC);
    chk(fault_code == 8'd1, "R8 clear while estop active", int'(fault_code), 1);
    estop_n = 1'b1;
    clear_cmd(CLRC);
    chk(fault_code == 8'd0 && gate_en, "R8 estop released", int'(fault_code), 0);

    // R2: overcurrent
    ocp_trip = 1'b1;
    #1;
    chk(gate_en == 1'b0 && force_off == 1'b1, "R2 ocp comb", int'(gate_en), 0);
    step();
    ocp_trip = 1'b0;
    step();
    chk(fault_code == 8'd2 && force_off, "R3 ocp held", int'(fault_code), 2);
    clear_cmd(CLRC);

    // R4: overvoltage boundary
    vbus_code = W'(OVL);
    step();
    chk(fault_code == 8'd0, "R4 at limit", int'(fault_code), 0);
    vbus_code = W'(OVL + 1);
    step();
    chk(fault_code == 8'd3 && !gate_en && !force_off, "R4 above limit", int'(fault_code), 3);
    vbus_code = W'(1920);
    clear_cmd(CLRC);

    // R5 / R9: undervoltage and hysteresis
    vbus_code = W'(UVL);
    step();
    chk(fault_code == 8'd0, "R5 at limit", int'(fault_code), 0);
    vbus_code = W'(UVL - 1);
    step();
    chk(fault_code == 8'd4, "R5 below limit", int'(fault_code), 4);
    vbus_code = W'(UVL + HYS - 1);
    clear_cmd(CLRC);
    chk(fault_code == 8'd4, "R9 inside band", int'(fault_code), 4);
    vbus_code = W'(UVL + HYS);
    clear_cmd(CLRC);
    chk(fault_code == 8'd0, "R9 release", int'(fault_code), 0);

    // R6 stall and R7 priority with a partial clear
    stall_flag = 1'b1;
    step();
    chk(fault_code == 8'd5, "R6 stall", int'(fault_code), 5);
    vbus_code = W'(OVL + 50);
    step();
    chk(fault_code == 8'd3, "R7 priority", int'(fault_code), 3);
    vbus_code = W'(1920);
    clear_cmd(CLRC);
    chk(fault_code == 8'd5, "R8 partial clear", int'(fault_code), 5);
    stall_flag = 1'b0;
    clear_cmd(CLRC);

    // R10: request low
    pwm_req = 1'b0;
    step();
    chk(gate_en == 1'b0, "R10 request low", int'(gate_en), 0);
    pwm_req = 1'b1;
    step();

    // random mix
    for (int k = 0; k < 4000; k++) begin
      estop_n    = ($urandom_range(0, 24) != 0);
      ocp_trip   = ($urandom_range(0, 24) == 0);
      stall_flag = ($urandom_range(0, 29) == 0);
      pwm_req    = ($urandom_range(0, 7) != 0);
      vbus_code  = W'($urandom_range(1400, 2440));
      cmd_valid  = ($urandom_range(0, 3) == 0);
      cmd_byte   = ($urandom_range(0, 3) != 0) ? CLRC : 8'($urandom_range(0, 255));
      #1;
      chk(gate_en == exp_gate(m_lat), "R1 R2 comb gate", int'(gate_en), int'(exp_gate(m_lat)));
      step();
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(64'd8 * 64'd200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule